// File: doc/BRIEF.md
# Synchronous Burst Read Front End

This block is the read-path controller that sits between the pins of a 128K x 16 word-addressed memory and its synchronous array read port. It supports two read styles, chosen by an active-low mode select. In the asynchronous style, the block forwards the presented address to the array on every cycle and shows the returned word. In the synchronous burst style, a start address is captured on a clock edge where the address-valid strobe is low. An internal counter then walks upward through the array, one word per clock, for as long as the strobe stays high.

The latency of the first word depends on the parity of the start address. An even start returns its first word two clock periods after the load, and an odd start returns it one period later. After that, words follow on every edge. A burst has no length limit and wraps from the highest word back to word zero. Loading a new address in the middle of a burst throws away any word still in flight. A data-valid flag marks each cycle that carries a fresh word. The output bus enable goes to the external tri-state driver.

Top module: `burst_read_fe`

## Requirements
- R1: `dqOe` is 1 only while `rstN` is 1, `ceN` is 0 and `oeN` is 0. Whenever `dqOe` is 0, `dq` reads as all zeros.
- R2: A load happens on a rising edge where `ceN`=0, `modeN`=0, `weN`=1 and `advN`=0. The load captures `addr` as the burst start address.
- R3: For an even start address (bit 0 = 0), the word at the start address appears on `dq` with `dataValid`=1 right after the second edge following the load edge. This assumes `advN`=1 on the edges in between.
- R4: For an odd start address (bit 0 = 1), the first word appears right after the third edge following the load edge. `dataValid` stays 0 before that.
- R5: While `advN` stays 1, each later edge presents the next higher word address. Each word appears two edges after the edge on which the counter stepped to it.
- R6: The counter wraps linearly, so word 0x1FFFF is followed by word 0x00000.
- R7: A load in the middle of a burst discards any pending word. `dataValid` is 0 after the load edge and stays 0 until the new start word arrives, with the latency given by R3 or R4.
- R8: With `modeN`=1 and `ceN`=0, `dq` shows the array word for the `addr` sampled at the previous edge, and `dataValid`=1. In this mode `advN` has no effect, and the burst counter keeps its position for a later return to burst mode.
- R9: On edges with `ceN`=1 or `weN`=0, `advN` neither loads nor advances the burst.
- R10: While `rstN` is 0, `dqOe` and `dataValid` are 0. After `rstN` is released, no word is presented until a load occurs.
- R11: `dataValid` is 1 for exactly one cycle per word delivered. It is 0 in the wait cycles of the odd-start penalty and in cycles after a suspended edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write strobe, active low (a write suspends the read path) |
| modeN | input | 1 | 0 = synchronous burst, 1 = asynchronous read |
| advN | input | 1 | 0 = load start address, 1 = advance the burst |
| addr | input | 17 | Word address |
| arrAddr | output | 17 | Array read address |
| arrRdEn | output | 1 | Array read strobe; the word returns after the next edge |
| arrData | input | 16 | Word returned by the array |
| dq | output | 16 | Data toward the tri-state driver |
| dqOe | output | 1 | Drive enable for the tri-state driver |
| dataValid | output | 1 | High for one cycle per fresh word |

## Verification
The bench builds the block with its default 17-bit address and 16-bit word. This lets the bench start bursts at 0x1FFFF and 0x1FFFE and watch the counter roll over to zero within a few cycles, for both start parities. The full-width address also lets the bench jump between asynchronous reads at far-apart addresses and a burst that is parked in the middle of the array. It can then confirm that the burst resumes exactly where it stopped.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture start address
    logic issue;    // read at counter, then step counter
    logic capture;  // register the returned array word
  } strobe_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    weN,
  input  logic    modeN,
  input  logic    advN,
  input  logic    startOdd,
  output strobe_t stb,
  output logic    asyncRd,
  output logic    asyncPend,
  output logic    validOut
);
  logic syncAct;
  logic started;
  logic stall;
  logic rdPend;

  assign syncAct     = !ceN && !modeN && weN;
  assign asyncRd     = !ceN && modeN && weN;
  assign stb.load    = syncAct && !advN;
  assign stb.issue   = syncAct && advN && started && !stall;
  assign stb.capture = rdPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started   <= 1'b0;
      stall     <= 1'b0;
      rdPend    <= 1'b0;
      validOut  <= 1'b0;
      asyncPend <= 1'b0;
    end else begin
      if (stb.load) begin
        started <= 1'b1;
        stall   <= startOdd;
      end else if (syncAct && advN) begin
        stall <= 1'b0;
      end
      rdPend    <= stb.issue;
      validOut  <= rdPend && !stb.load;
      asyncPend <= asyncRd;
    end
  end

  // R7
  reload_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !validOut);

  // R4
  odd_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && startOdd) |=> !stb.issue);

  // R11
  single_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> !(asyncPend && $past(stb.issue)));
endmodule

// File: rtl/burst_dpath.sv
module burst_dpath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              asyncRd,
  input  logic              asyncPend,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] arrData,
  output logic [ADDR_W-1:0] arrAddr,
  output logic              arrRdEn,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] dqWord
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] cnt;
  logic [DATA_W-1:0] dqReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      dqReg <= '0;
    end else begin
      if (stb.load)        cnt <= addr;
      else if (stb.issue)  cnt <= cnt + STEP;
      if (stb.capture)     dqReg <= arrData;
    end
  end

  assign arrAddr = asyncRd ? addr : cnt;
  assign arrRdEn = asyncRd || stb.issue;
  assign curAddr = cnt;
  assign dqWord  = asyncPend ? arrData : dqReg;

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.issue && (cnt == '1)) |=> (cnt == '0));
endmodule

// File: rtl/burst_read_fe.sv
module burst_read_fe
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              modeN,
  input  logic              advN,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] arrAddr,
  output logic              arrRdEn,
  input  logic [DATA_W-1:0] arrData,
  output logic [DATA_W-1:0] dq,
  output logic              dqOe,
  output logic              dataValid
);
  strobe_t           stb;
  logic              asyncRd;
  logic              asyncPend;
  logic              validOut;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] dqWord;

  burst_ctrl ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .modeN(modeN),
    .advN(advN), .startOdd(addr[0]), .stb(stb), .asyncRd(asyncRd),
    .asyncPend(asyncPend), .validOut(validOut)
  );

  burst_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .asyncRd(asyncRd),
    .asyncPend(asyncPend), .addr(addr), .arrData(arrData),
    .arrAddr(arrAddr), .arrRdEn(arrRdEn), .curAddr(curAddr),
    .dqWord(dqWord)
  );

  assign dqOe      = rstN && !ceN && !oeN;
  assign dq        = dqOe ? dqWord : '0;
  assign dataValid = validOut || asyncPend;

  // R8
  async_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && modeN) |=> $stable(curAddr));

  // R9
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || !weN) |=> $stable(curAddr));
endmodule

// File: tb/burst_read_fe_test.sv
module burst_read_fe_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1, modeN = 1'b0, advN = 1'b1;
  logic [16:0] addr = '0;
  logic [16:0] arrAddr;
  logic        arrRdEn;
  logic [15:0] arrData = '0;
  logic [15:0] dq;
  logic        dqOe, dataValid;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  burst_read_fe uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .modeN(modeN),
    .advN(advN), .addr(addr), .arrAddr(arrAddr), .arrRdEn(arrRdEn),
    .arrData(arrData), .dq(dq), .dqOe(dqOe), .dataValid(dataValid)
  );

  function automatic logic [15:0] memWord(input logic [16:0] a);
    return a[15:0] ^ {a[16], 15'h2B6D};
  endfunction

  // synchronous array model: word returns after the edge that reads it
  always @(posedge clk) if (arrRdEn) arrData <= memWord(arrAddr);

  typedef struct packed {
    logic        advN, modeN, ceN, oeN, weN;
    logic [16:0] addr;
    logic        vld;
    logic [16:0] expA;
    logic        oe;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h00010,1'b0,17'h00000,1'b1}, // 0 R2 load even
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b0,17'h00000,1'b1}, // 1 R3
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00010,1'b1}, // 2 R3 first word
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00011,1'b1}, // 3 R5
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00012,1'b1}, // 4 R5
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h00101,1'b0,17'h00000,1'b1}, // 5 R7 reload odd
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b0,17'h00000,1'b1}, // 6 R4 R11
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b0,17'h00000,1'b1}, // 7 R4 R11
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00101,1'b1}, // 8 R4 first word
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00102,1'b1}, // 9 R5
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h1FFFF,1'b0,17'h00000,1'b1}, // 10 R7 load top
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b0,17'h00000,1'b1}, // 11 R4
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b0,17'h00000,1'b1}, // 12 R4
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h1FFFF,1'b1}, // 13 R4
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00000,1'b1}, // 14 R6 wrap
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00001,1'b1}, // 15 R6
    '{1'b0,1'b0,1'b0,1'b0,1'b1,17'h1FFFE,1'b0,17'h00000,1'b1}, // 16 R2
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b0,17'h00000,1'b1}, // 17 R3
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h1FFFE,1'b1}, // 18 R3
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h1FFFF,1'b1}, // 19 R5
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00000,1'b1}, // 20 R6
    '{1'b1,1'b0,1'b0,1'b1,1'b1,17'h00000,1'b1,17'h00001,1'b0}, // 21 R1 oe high
    '{1'b1,1'b0,1'b1,1'b0,1'b1,17'h00000,1'b1,17'h00002,1'b0}, // 22 R1 R9 ce high
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b0,17'h00000,1'b1}, // 23 R9 R11
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00003,1'b1}, // 24 R9 resumed
    '{1'b0,1'b0,1'b0,1'b0,1'b0,17'h00500,1'b1,17'h00004,1'b1}, // 25 R9 write, no load
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b0,17'h00000,1'b1}, // 26 R9
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00005,1'b1}, // 27 R9 continues
    '{1'b0,1'b1,1'b0,1'b0,1'b1,17'h00ABC,1'b1,17'h00ABC,1'b1}, // 28 R8 async
    '{1'b0,1'b1,1'b0,1'b0,1'b1,17'h01234,1'b1,17'h01234,1'b1}, // 29 R8
    '{1'b1,1'b1,1'b0,1'b0,1'b1,17'h1FFFF,1'b1,17'h1FFFF,1'b1}, // 30 R8
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b0,17'h00000,1'b1}, // 31 R8 back to burst
    '{1'b1,1'b0,1'b0,1'b0,1'b1,17'h00000,1'b1,17'h00007,1'b1}  // 32 R8 counter kept
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    ceN = 1'b0; oeN = 1'b0;
    #12;
    check("R10 reset oe", {31'd0, dqOe}, 32'd0);
    check("R10 reset valid", {31'd0, dataValid}, 32'd0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      advN = VEC[i].advN; modeN = VEC[i].modeN; ceN = VEC[i].ceN;
      oeN = VEC[i].oeN; weN = VEC[i].weN; addr = VEC[i].addr;
      @(posedge clk); #2;
      check($sformatf("R1 oe row %0d", i), {31'd0, dqOe}, {31'd0, VEC[i].oe});
      check($sformatf("R11 valid row %0d", i), {31'd0, dataValid}, {31'd0, VEC[i].vld});
      if (!VEC[i].oe)
        check($sformatf("R1 idle bus row %0d", i), {16'd0, dq}, 32'd0);
      else if (VEC[i].vld)
        check($sformatf("R5 word row %0d", i), {16'd0, dq}, {16'd0, memWord(VEC[i].expA)});
    end

    // R10: reset mid burst, then no words until a load
    @(negedge clk); advN = 1'b1; rstN = 1'b0;
    #1;
    check("R10 oe in reset", {31'd0, dqOe}, 32'd0);
    check("R10 valid in reset", {31'd0, dataValid}, 32'd0);
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      check("R10 idle after reset", {31'd0, dataValid}, 32'd0);
    end

    // R3: fresh even load after reset
    @(negedge clk); advN = 1'b0; addr = 17'h00200;
    @(negedge clk); advN = 1'b1;
    @(posedge clk); #2;
    check("R3 wait edge", {31'd0, dataValid}, 32'd0);
    @(posedge clk); #2;
    check("R3 valid", {31'd0, dataValid}, 32'd1);
    check("R3 word", {16'd0, dq}, {16'd0, memWord(17'h00200)});

    // R7: reload one edge after load discards the first start
    @(negedge clk); advN = 1'b0; addr = 17'h00300;
    @(negedge clk); advN = 1'b0; addr = 17'h00400;
    @(negedge clk); advN = 1'b1;
    @(posedge clk); #2;
    check("R7 flushed", {31'd0, dataValid}, 32'd0);
    @(posedge clk); #2;
    check("R7 new word", {16'd0, dq}, {16'd0, memWord(17'h00400)});
    check("R7 new valid", {31'd0, dataValid}, 32'd1);

    done = 1'b1;
    finishRun();
  end
endmodule